// File: doc/BRIEF.md
# OTG Role and Supply Detection Sequencer

This block decides which role a dual-role USB port takes and keeps the port's override fields up to date. It samples an identification input and a supply-present input and resolves them against a configured role mode. The modes are host, peripheral and dual-role. When an input changes, the block writes forced values into the ID and supply fields of a control word. It also sets the routing bit that chooses between the host and device controllers, and it pulses a notification strobe for each field that changed.

Input edges are debounced. An input that cannot report edges is rescanned on a fixed period. When the role changes in a way that needs the previous session torn down, the block holds the supply field forced low for a timed window. For entry into host role this window comes before the ID field is rewritten. For entry into peripheral role it comes after. All delays count pulses of a one-per-millisecond tick input. While the port is not initialised the sequencer stays idle.

Top module: `otg_role_detect`

## Requirements
- R1: After reset the control word `stat_ctrl` and `route_sel` are all zero and both strobes are low.
- R2: A rising `port_init` sets bit 17 (ID pull-up) and bit 16 (line pull-up) of `stat_ctrl`, and a falling `port_init` clears both.
- R3: On initialisation both cached states are invalid, so within a few ticks both force fields are written and both strobes pulse. A force field is bits 15:14 for ID and bits 13:12 for supply, with 2'b10 meaning forced low and 2'b11 forced high.
- R4: `role_mode` encoding is 2'b00 peripheral, 2'b01 host, 2'b10 dual-role, and 2'b11 acts as peripheral. The resolved ID is 0 in host, 1 in peripheral, and in dual-role it follows `id_pin`, or is 1 when `id_present` is low.
- R5: The supply field follows `vbus_pin` when `vbus_present` is high and reports high when it is low.
- R6: Any edge on a present, edge-capable input restarts a DEBOUNCE_MS (50) tick wait, and the inputs are sampled only when it ends.
- R7: When a present input is not edge-capable, the inputs are rescanned every POLL_MS (250) ticks.
- R8: A change of `role_mode` rescans at once and forces a session end.
- R9: On a forced session end to ID 0, the supply field is 2'b10 for HOST_END_MS (200) ticks, then 2'b11, and only then is the ID field written.
- R10: On a forced session end to ID 1, the ID field is written and strobed first, then the supply field is 2'b10 for DEV_END_MS (1000) ticks, then 2'b11.
- R11: In dual-role mode with `vbus_present` low, every ID change forces a session end.
- R12: With `dual_route_en` high, each ID update sets `route_sel` to the new ID (0 host, 1 peripheral). With it low, `route_sel` holds.
- R13: While `port_init` is low, input changes update no field and raise no strobe.
- R14: Each strobe is a single-cycle pulse, given only when its cached value changes or was invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| port_init | input | 1 | Port initialised (level) |
| role_mode | input | 2 | Configured role mode |
| dual_route_en | input | 1 | Enable routing-bit updates |
| id_pin | input | 1 | Identification input level |
| id_present | input | 1 | ID input is wired |
| id_edge_cap | input | 1 | ID input can report edges |
| vbus_pin | input | 1 | Supply-present input level |
| vbus_present | input | 1 | Supply source is wired |
| vbus_edge_cap | input | 1 | Supply input can report edges |
| stat_ctrl | output | 18 | Control word: pull-ups and force fields |
| route_sel | output | 1 | Port routing: 0 host, 1 device |
| id_chg_stb | output | 1 | ID field updated |
| vbus_chg_stb | output | 1 | Supply field updated |

## Verification
The checker watches, on every cycle, the pull-up bits following `port_init`, the absence of the reserved 2'b01 code in both force fields, strobe width, silence while uninitialised, and the coupling of ID-field and routing changes to an ID strobe. Debounce restart, polling latency, the exact order of session-end windows against the ID update, and their lengths in ticks are shown only by the bench's timed scenarios.

// File: rtl/otg_det_pkg.sv
package otg_det_pkg;

   localparam int REG_W        = 18;
   localparam int ID_PU_BIT    = 17;
   localparam int LINE_PU_BIT  = 16;
   localparam int ID_FRC_LSB   = 14;
   localparam int VB_FRC_LSB   = 12;

   localparam logic [1:0] FRC_NONE = 2'b00;
   localparam logic [1:0] FRC_LOW  = 2'b10;
   localparam logic [1:0] FRC_HIGH = 2'b11;

   typedef enum logic [1:0] {
      ROLE_PERIPH = 2'b00,
      ROLE_HOST   = 2'b01,
      ROLE_DUAL   = 2'b10,
      ROLE_RSVD   = 2'b11
   } role_e;

   typedef enum logic [2:0] {
      ST_OFF,
      ST_WAIT,
      ST_EVAL,
      ST_PRE,
      ST_APPLY,
      ST_POST,
      ST_RESUME
   } seq_st_e;

   function automatic logic [1:0] frc_enc(input logic v);
      return v ? FRC_HIGH : FRC_LOW;
   endfunction

endpackage

// File: rtl/otg_pin_sync.sv
module otg_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else if (STAGES == 1) begin : g_one
         logic r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= 1'b0;
            else        r <= d;
         end
         assign q = r;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[STAGES-2:0], d};
         end
         assign q = sh[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/otg_edge_watch.sv
module otg_edge_watch #(
   parameter int N           = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pins,
   input  logic [N-1:0] present,
   input  logic [N-1:0] edge_cap,
   output logic [N-1:0] lvl,
   output logic         evt
);

   logic [N-1:0] prev;
   logic [N-1:0] hit;

   for (genvar i = 0; i < N; i++) begin : g_ch
      otg_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (pins[i]),
         .q     (lvl[i])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev[i] <= 1'b0;
         else        prev[i] <= lvl[i];
      end

      assign hit[i] = (lvl[i] ^ prev[i]) & present[i] & edge_cap[i];
   end

   assign evt = |hit;

endmodule

// File: rtl/otg_ms_timer.sv
module otg_ms_timer #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         tick,
   output logic         busy,
   output logic         done
);

   logic [W-1:0] cnt;
   logic         run;

   assign busy = run;
   assign done = run & (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         run <= 1'b0;
      end else if (clr) begin
         run <= 1'b0;
      end else if (load) begin
         cnt <= load_val;
         run <= 1'b1;
      end else if (done) begin
         run <= 1'b0;
      end else if (run && tick) begin
         cnt <= cnt - 1'b1;
      end
   end

endmodule

// File: rtl/otg_role_resolve.sv
module otg_role_resolve
   import otg_det_pkg::*;
(
   input  logic [1:0] role_mode,
   input  logic       id_lvl,
   input  logic       id_present,
   input  logic       id_edge_cap,
   input  logic       vbus_lvl,
   input  logic       vbus_present,
   input  logic       vbus_edge_cap,
   output logic       id_eff,
   output logic       vbus_eff,
   output logic       poll_need
);

   role_e role;
   assign role = role_e'(role_mode);

   always_comb begin
      unique case (role)
         ROLE_HOST: id_eff = 1'b0;
         ROLE_DUAL: id_eff = id_present ? id_lvl : 1'b1;
         default:   id_eff = 1'b1;
      endcase
   end

   assign vbus_eff  = vbus_present ? vbus_lvl : 1'b1;
   assign poll_need = (id_present & ~id_edge_cap) | (vbus_present & ~vbus_edge_cap);

endmodule

// File: rtl/otg_detect_seq.sv
module otg_detect_seq
   import otg_det_pkg::*;
#(
   parameter int TW          = 10,
   parameter int DEBOUNCE_MS = 50,
   parameter int POLL_MS     = 250,
   parameter int HOST_END_MS = 200,
   parameter int DEV_END_MS  = 1000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             port_init,
   input  logic [1:0]       role_mode,
   input  logic             dual_route_en,
   input  logic             pin_evt,
   input  logic             id_eff,
   input  logic             vbus_eff,
   input  logic             vbus_src,
   input  logic             poll_need,
   input  logic             tmr_busy,
   input  logic             tmr_done,
   output logic             tmr_clr,
   output logic             tmr_load,
   output logic [TW-1:0]    tmr_val,
   output logic [REG_W-1:0] stat_ctrl,
   output logic             route_sel,
   output logic             id_stb,
   output logic             vbus_stb
);

   seq_st_e    st;
   logic [1:0] mode_q;
   logic       id_c, id_vld, vbus_c, vbus_vld;
   logic       fe_req, fe_act, pend_deb;
   logic       id_new, vbus_new, id_upd;
   logic [1:0] id_frc, vb_frc;
   logic       pu_id, pu_line, route_q;
   logic       id_stb_q, vb_stb_q;

   logic mode_evt, id_chg, fe_now;

   assign mode_evt = (role_mode != mode_q);
   assign id_chg   = !id_vld || (id_eff != id_c);
   assign fe_now   = fe_req || (id_chg && (role_e'(role_mode) == ROLE_DUAL) && !vbus_src);

   // timer control
   always_comb begin
      tmr_clr  = 1'b0;
      tmr_load = 1'b0;
      tmr_val  = '0;
      if (!port_init) begin
         tmr_clr = 1'b1;
      end else begin
         unique case (st)
            ST_OFF: begin
               tmr_load = 1'b1;
            end
            ST_WAIT: begin
               if (mode_evt) begin
                  tmr_load = 1'b1;
               end else if (pin_evt) begin
                  tmr_load = 1'b1;
                  tmr_val  = TW'(DEBOUNCE_MS);
               end else if (!tmr_busy && poll_need) begin
                  tmr_load = 1'b1;
                  tmr_val  = TW'(POLL_MS);
               end
            end
            ST_EVAL: begin
               if (id_chg && fe_now && !id_eff) begin
                  tmr_load = 1'b1;
                  tmr_val  = TW'(HOST_END_MS);
               end
            end
            ST_APPLY: begin
               if (id_upd && fe_act && id_new) begin
                  tmr_load = 1'b1;
                  tmr_val  = TW'(DEV_END_MS);
               end
            end
            ST_RESUME: begin
               if (mode_evt) begin
                  tmr_load = 1'b1;
               end else if (pend_deb || pin_evt) begin
                  tmr_load = 1'b1;
                  tmr_val  = TW'(DEBOUNCE_MS);
               end else if (poll_need) begin
                  tmr_load = 1'b1;
                  tmr_val  = TW'(POLL_MS);
               end
            end
            default: ;
         endcase
      end
   end

   // sequencer state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_OFF;
         mode_q   <= 2'b00;
         id_c     <= 1'b0;
         id_vld   <= 1'b0;
         vbus_c   <= 1'b0;
         vbus_vld <= 1'b0;
         fe_req   <= 1'b0;
         fe_act   <= 1'b0;
         pend_deb <= 1'b0;
         id_new   <= 1'b0;
         vbus_new <= 1'b0;
         id_upd   <= 1'b0;
         id_frc   <= FRC_NONE;
         vb_frc   <= FRC_NONE;
         pu_id    <= 1'b0;
         pu_line  <= 1'b0;
         route_q  <= 1'b0;
         id_stb_q <= 1'b0;
         vb_stb_q <= 1'b0;
      end else begin
         id_stb_q <= 1'b0;
         vb_stb_q <= 1'b0;
         if (!port_init) begin
            if (st == ST_PRE || st == ST_POST) vb_frc <= FRC_HIGH;
            st       <= ST_OFF;
            pu_id    <= 1'b0;
            pu_line  <= 1'b0;
            fe_req   <= 1'b0;
            pend_deb <= 1'b0;
            mode_q   <= role_mode;
         end else begin
            unique case (st)
               ST_OFF: begin
                  pu_id    <= 1'b1;
                  pu_line  <= 1'b1;
                  id_vld   <= 1'b0;
                  vbus_vld <= 1'b0;
                  fe_req   <= 1'b0;
                  pend_deb <= 1'b0;
                  mode_q   <= role_mode;
                  st       <= ST_WAIT;
               end
               ST_WAIT: begin
                  if (mode_evt) begin
                     mode_q <= role_mode;
                     fe_req <= 1'b1;
                     id_vld <= 1'b0;
                  end else if (!pin_evt && tmr_done) begin
                     st <= ST_EVAL;
                  end
               end
               ST_EVAL: begin
                  pend_deb <= pend_deb | pin_evt;
                  id_new   <= id_eff;
                  vbus_new <= vbus_eff;
                  id_upd   <= id_chg;
                  fe_act   <= fe_now;
                  fe_req   <= 1'b0;
                  if (id_chg && fe_now && !id_eff) begin
                     vb_frc <= FRC_LOW;
                     st     <= ST_PRE;
                  end else begin
                     st <= ST_APPLY;
                  end
               end
               ST_PRE: begin
                  pend_deb <= pend_deb | pin_evt;
                  if (tmr_done) begin
                     vb_frc <= FRC_HIGH;
                     st     <= ST_APPLY;
                  end
               end
               ST_APPLY: begin
                  pend_deb <= pend_deb | pin_evt;
                  if (id_upd) begin
                     id_frc   <= frc_enc(id_new);
                     id_c     <= id_new;
                     id_vld   <= 1'b1;
                     id_stb_q <= 1'b1;
                     if (dual_route_en) route_q <= id_new;
                  end
                  if (!vbus_vld || (vbus_new != vbus_c)) begin
                     vb_frc   <= frc_enc(vbus_new);
                     vbus_c   <= vbus_new;
                     vbus_vld <= 1'b1;
                     vb_stb_q <= 1'b1;
                  end
                  if (id_upd && fe_act && id_new) begin
                     vb_frc <= FRC_LOW;
                     st     <= ST_POST;
                  end else begin
                     st <= ST_RESUME;
                  end
               end
               ST_POST: begin
                  pend_deb <= pend_deb | pin_evt;
                  if (tmr_done) begin
                     vb_frc <= FRC_HIGH;
                     st     <= ST_RESUME;
                  end
               end
               ST_RESUME: begin
                  pend_deb <= 1'b0;
                  if (mode_evt) begin
                     mode_q <= role_mode;
                     fe_req <= 1'b1;
                     id_vld <= 1'b0;
                  end
                  st <= ST_WAIT;
               end
               default: st <= ST_OFF;
            endcase
         end
      end
   end

   always_comb begin
      stat_ctrl                              = '0;
      stat_ctrl[ID_PU_BIT]                   = pu_id;
      stat_ctrl[LINE_PU_BIT]                 = pu_line;
      stat_ctrl[ID_FRC_LSB+1:ID_FRC_LSB]     = id_frc;
      stat_ctrl[VB_FRC_LSB+1:VB_FRC_LSB]     = vb_frc;
   end

   assign route_sel = route_q;
   assign id_stb    = id_stb_q;
   assign vbus_stb  = vb_stb_q;

endmodule

// File: rtl/otg_role_detect.sv
module otg_role_detect
   import otg_det_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int DEBOUNCE_MS = 50,
   parameter int POLL_MS     = 250,
   parameter int HOST_END_MS = 200,
   parameter int DEV_END_MS  = 1000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ms_tick,
   input  logic             port_init,
   input  logic [1:0]       role_mode,
   input  logic             dual_route_en,
   input  logic             id_pin,
   input  logic             id_present,
   input  logic             id_edge_cap,
   input  logic             vbus_pin,
   input  logic             vbus_present,
   input  logic             vbus_edge_cap,
   output logic [REG_W-1:0] stat_ctrl,
   output logic             route_sel,
   output logic             id_chg_stb,
   output logic             vbus_chg_stb
);

   localparam int MAX_A  = (DEBOUNCE_MS > POLL_MS) ? DEBOUNCE_MS : POLL_MS;
   localparam int MAX_B  = (HOST_END_MS > DEV_END_MS) ? HOST_END_MS : DEV_END_MS;
   localparam int MAX_MS = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int TW     = $clog2(MAX_MS + 1);

   if (DEBOUNCE_MS < 1 || POLL_MS < 1) begin : g_bad_wait
      $error("otg_role_detect: debounce and poll periods must be at least one tick");
   end
   if (HOST_END_MS < 1 || DEV_END_MS < 1) begin : g_bad_end
      $error("otg_role_detect: session-end windows must be at least one tick");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("otg_role_detect: SYNC_STAGES must lie in 0..4");
   end

   logic [1:0]    lvl;
   logic          pin_evt;
   logic          id_eff, vbus_eff, poll_need;
   logic          tmr_clr, tmr_load, tmr_busy, tmr_done;
   logic [TW-1:0] tmr_val;

   otg_edge_watch #(.N(2), .SYNC_STAGES(SYNC_STAGES)) i_watch (
      .clk      (clk),
      .rst_n    (rst_n),
      .pins     ({vbus_pin, id_pin}),
      .present  ({vbus_present, id_present}),
      .edge_cap ({vbus_edge_cap, id_edge_cap}),
      .lvl      (lvl),
      .evt      (pin_evt)
   );

   otg_role_resolve i_resolve (
      .role_mode     (role_mode),
      .id_lvl        (lvl[0]),
      .id_present    (id_present),
      .id_edge_cap   (id_edge_cap),
      .vbus_lvl      (lvl[1]),
      .vbus_present  (vbus_present),
      .vbus_edge_cap (vbus_edge_cap),
      .id_eff        (id_eff),
      .vbus_eff      (vbus_eff),
      .poll_need     (poll_need)
   );

   otg_ms_timer #(.W(TW)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (tmr_clr),
      .load     (tmr_load),
      .load_val (tmr_val),
      .tick     (ms_tick),
      .busy     (tmr_busy),
      .done     (tmr_done)
   );

   otg_detect_seq #(
      .TW          (TW),
      .DEBOUNCE_MS (DEBOUNCE_MS),
      .POLL_MS     (POLL_MS),
      .HOST_END_MS (HOST_END_MS),
      .DEV_END_MS  (DEV_END_MS)
   ) i_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .port_init     (port_init),
      .role_mode     (role_mode),
      .dual_route_en (dual_route_en),
      .pin_evt       (pin_evt),
      .id_eff        (id_eff),
      .vbus_eff      (vbus_eff),
      .vbus_src      (vbus_present),
      .poll_need     (poll_need),
      .tmr_busy      (tmr_busy),
      .tmr_done      (tmr_done),
      .tmr_clr       (tmr_clr),
      .tmr_load      (tmr_load),
      .tmr_val       (tmr_val),
      .stat_ctrl     (stat_ctrl),
      .route_sel     (route_sel),
      .id_stb        (id_chg_stb),
      .vbus_stb      (vbus_chg_stb)
   );

endmodule

// File: rtl/otg_role_detect_chk.sv
module otg_role_detect_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        port_init,
   input logic        dual_route_en,
   input logic [17:0] stat_ctrl,
   input logic        route_sel,
   input logic        id_chg_stb,
   input logic        vbus_chg_stb
);

   p_pullup_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(port_init) |=> stat_ctrl[17:16] == 2'b11);

   p_pullup_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !port_init |=> stat_ctrl[17:16] == 2'b00);

   p_force_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
      stat_ctrl[15:14] != 2'b01 && stat_ctrl[13:12] != 2'b01);

   p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !port_init |=> !id_chg_stb && !vbus_chg_stb);

   p_id_stb_pulse_r14: assert property (@(posedge clk) disable iff (!rst_n)
      id_chg_stb |=> !id_chg_stb);

   p_vbus_stb_pulse_r14: assert property (@(posedge clk) disable iff (!rst_n)
      vbus_chg_stb |=> !vbus_chg_stb);

   p_id_field_stb_r14: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(stat_ctrl[15:14]) |-> id_chg_stb);

   p_route_move_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(route_sel) |-> id_chg_stb && $past(dual_route_en));

   p_route_match_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (id_chg_stb && $past(dual_route_en)) |-> route_sel == (stat_ctrl[15:14] == 2'b11));

endmodule

bind otg_role_detect otg_role_detect_chk i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .port_init     (port_init),
   .dual_route_en (dual_route_en),
   .stat_ctrl     (stat_ctrl),
   .route_sel     (route_sel),
   .id_chg_stb    (id_chg_stb),
   .vbus_chg_stb  (vbus_chg_stb)
);

// File: tb/test_otg_role_detect.sv
`timescale 1ns/1ps
module test_otg_role_detect;

   localparam int TDIV = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ms_tick = 1'b0;
   logic        port_init = 1'b0;
   logic [1:0]  role_mode = 2'b00;
   logic        dual_route_en = 1'b1;
   logic        id_pin = 1'b1, id_present = 1'b1, id_edge_cap = 1'b1;
   logic        vbus_pin = 1'b0, vbus_present = 1'b1, vbus_edge_cap = 1'b1;
   logic [17:0] stat_ctrl;
   logic        route_sel, id_chg_stb, vbus_chg_stb;

   int checks = 0;
   int errors = 0;
   int n_id = 0;
   int n_vb = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   otg_role_detect i_otg_role_detect (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .port_init(port_init),
      .role_mode(role_mode), .dual_route_en(dual_route_en),
      .id_pin(id_pin), .id_present(id_present), .id_edge_cap(id_edge_cap),
      .vbus_pin(vbus_pin), .vbus_present(vbus_present), .vbus_edge_cap(vbus_edge_cap),
      .stat_ctrl(stat_ctrl), .route_sel(route_sel),
      .id_chg_stb(id_chg_stb), .vbus_chg_stb(vbus_chg_stb)
   );

   always @(negedge clk) begin
      if (id_chg_stb)   n_id++;
      if (vbus_chg_stb) n_vb++;
   end

   initial begin
      forever begin
         repeat (TDIV - 1) @(negedge clk);
         ms_tick = 1'b1;
         @(negedge clk);
         ms_tick = 1'b0;
      end
   end

   function automatic logic [1:0] enc(input logic v);
      return v ? 2'b11 : 2'b10;
   endfunction

   function automatic logic exp_id(input logic [1:0] m, input logic pres, input logic pin);
      if (m == 2'b01) return 1'b0;
      if (m == 2'b10) return pres ? pin : 1'b1;
      return 1'b1;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      repeat (n * TDIV) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int sid, svb;
      void'($urandom(32'h5EED));
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      check("R1 ctrl", stat_ctrl, 0);
      check("R1 route", route_sel, 0);
      check("R1 strobes", {id_chg_stb, vbus_chg_stb}, 0);

      // R13: idle while not initialised
      id_pin = 1'b0; ticks(3); vbus_pin = 1'b1; ticks(3);
      id_pin = 1'b1; vbus_pin = 1'b0; ticks(60);
      check("R13 ctrl idle", stat_ctrl, 0);
      check("R13 no strobes", n_id + n_vb, 0);

      // R2/R3/R12: init in peripheral mode, supply low
      port_init = 1'b1;
      ticks(3);
      check("R2 pullups set", stat_ctrl[17:16], 2'b11);
      check("R3 id field", stat_ctrl[15:14], 2'b11);
      check("R3 vbus field", stat_ctrl[13:12], 2'b10);
      check("R3 strobes", {n_id[7:0], n_vb[7:0]}, 16'h0101);
      check("R12 route periph", route_sel, 1);

      // R14/R6: glitch returning to old value
      vbus_pin = 1'b1; ticks(1); vbus_pin = 1'b0;
      ticks(60);
      check("R14 glitch field", stat_ctrl[13:12], 2'b10);
      check("R14 glitch no strobe", n_vb, 1);

      // R6: second edge restarts debounce
      vbus_pin = 1'b1;
      ticks(30);
      id_pin = 1'b0;
      ticks(45);
      check("R6 not yet sampled", stat_ctrl[13:12], 2'b10);
      ticks(11);
      check("R6 sampled after restart", stat_ctrl[13:12], 2'b11);
      check("R5 vbus follows pin", n_vb, 2);
      check("R14 id unchanged no strobe", n_id, 1);
      check("R4 periph ignores pin", stat_ctrl[15:14], 2'b11);
      id_pin = 1'b1;
      ticks(60);

      // R8/R10: mode change to dual-role, id 1 -> session end after id update
      role_mode = 2'b10;
      ticks(5);
      check("R8 immediate rescan", n_id, 2);
      check("R10 id written first", stat_ctrl[15:14], 2'b11);
      check("R10 vbus forced low", stat_ctrl[13:12], 2'b10);
      ticks(985);
      check("R10 still low", stat_ctrl[13:12], 2'b10);
      ticks(20);
      check("R10 released high", stat_ctrl[13:12], 2'b11);

      // R4/R5/R12 random dual-role traffic
      for (int i = 0; i < 8; i++) begin
         logic nid, nvb;
         nid = 1'(($urandom >> 3) & 1);
         nvb = 1'(($urandom >> 5) & 1);
         id_pin = nid; vbus_pin = nvb;
         ticks(60);
         check("R4 random id", stat_ctrl[15:14], enc(exp_id(2'b10, 1'b1, nid)));
         check("R5 random vbus", stat_ctrl[13:12], enc(nvb));
         check("R12 random route", route_sel, exp_id(2'b10, 1'b1, nid));
      end

      // R4: dual-role pin low, then pin absent reads 1
      id_pin = 1'b0; ticks(60);
      check("R4 dual follows pin", stat_ctrl[15:14], 2'b10);
      id_present = 1'b0; ticks(1);
      vbus_pin = ~vbus_pin; ticks(60);
      check("R4 absent id high", stat_ctrl[15:14], 2'b11);
      check("R5 vbus toggle", stat_ctrl[13:12], enc(vbus_pin));

      // R12: routing frozen when disabled
      dual_route_en = 1'b0;
      id_present = 1'b1; ticks(1);
      vbus_pin = ~vbus_pin; ticks(60);
      check("R12 id host", stat_ctrl[15:14], 2'b10);
      check("R12 route held", route_sel, 1);
      dual_route_en = 1'b1;

      // R7: polling when id cannot raise edges
      id_edge_cap = 1'b0; ticks(1);
      sid = n_id;
      id_pin = 1'b1;
      ticks(270);
      check("R7 poll picked up id", stat_ctrl[15:14], 2'b11);
      check("R7 strobe", n_id, sid + 1);
      id_edge_cap = 1'b1;
      ticks(2);

      // R9/R11: no supply source, id falls -> low window before id update
      vbus_present = 1'b0;
      ticks(2);
      id_pin = 1'b0;
      ticks(55);
      check("R11 auto session end", stat_ctrl[13:12], 2'b10);
      check("R9 id not yet", stat_ctrl[15:14], 2'b11);
      ticks(190);
      check("R9 low window", stat_ctrl[13:12], 2'b10);
      ticks(13);
      check("R9 released", stat_ctrl[13:12], 2'b11);
      check("R9 id after window", stat_ctrl[15:14], 2'b10);
      check("R12 route host", route_sel, 0);

      // R10/R11: id rises -> id update then long low window
      svb = n_vb;
      id_pin = 1'b1;
      ticks(55);
      check("R10 id first", stat_ctrl[15:14], 2'b11);
      check("R11 low after id", stat_ctrl[13:12], 2'b10);
      ticks(990);
      check("R10 long window", stat_ctrl[13:12], 2'b10);
      ticks(13);
      check("R10 window end", stat_ctrl[13:12], 2'b11);
      check("R5 absent reads high", n_vb, svb);
      check("R12 route periph", route_sel, 1);

      // R2: exit
      port_init = 1'b0;
      ticks(2);
      check("R2 pullups cleared", stat_ctrl[17:16], 2'b00);
      check("R2 fields held", stat_ctrl[15:12], 4'hF);

      finish_run();
   end

endmodule